// File: doc/BRIEF.md
# Serial Bit-Pattern Watcher (1-0-1-1)

This block samples a single serial data line on every rising clock edge. It raises a flag when the four most recent bits, oldest first, are 1, 0, 1, 1. Occurrences may overlap: the final 1 of one match can start the next. For example, the stream 1 0 1 1 0 1 1 yields two matches.

The block holds two independent state machines and drives one flag from each:

- **Early flag (`hit_now`).** Comes from a four-state machine with two state bits. The states are IDLE (nothing useful), GOT1, GOT10 and GOT101. The flag is combinational. It is high in the same cycle as the closing 1 is presented on `din`.
- **Late flag (`hit_reg`).** Comes from a five-state machine with the states IDLE, GOT1, GOT10, GOT101 and FOUND. The flag is decoded from the present state only. It is high exactly while the machine sits in FOUND, which is one cycle after the early flag.

A synchronous clear input sends both machines to IDLE at the next edge, whatever `din` holds.

The transitions are named here as (state, input) -> state:

| From | `din` = 1 | `din` = 0 |
|------|-----------|-----------|
| IDLE | GOT1 | IDLE |
| GOT1 | GOT1 | GOT10 |
| GOT10 | GOT101 | IDLE |
| GOT101 | early machine: GOT1, with a match; late machine: FOUND | GOT10 |
| FOUND (late machine only) | GOT1 | GOT10 |

Top module: `bitseq_watch`

## Requirements
- R1: A rising edge with `sync_clr` high puts both machines in IDLE. In the cycle after such an edge, `hit_reg` is 0, and no bit sampled before or during the clear counts toward a match.
- R2: `hit_now` is 1 exactly when all of the following hold: `din` is 1, `sync_clr` is 0, and the last three bits sampled since the clear were 1, 0, 1 in arrival order.
- R3: Matches overlap. The stream 1,0,1,1,0,1,1 gives two early-flag pulses, and `hit_now` is never high in two consecutive cycles.
- R4: `hit_reg` in every cycle equals `hit_now` from the previous cycle.
- R5: `hit_reg` is never high in two consecutive cycles, because FOUND always exits on the next edge.
- R6: While `sync_clr` is high, `hit_now` is 0, even when the machine is in GOT101 and `din` is 1.
- R7: After a mismatch, the longest usable prefix is kept. Both 1,1,0,1,1 and 1,0,1,0,1,1 produce a match on their last bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| sync_clr | input | 1 | Synchronous clear, active high |
| din | input | 1 | Serial data bit, sampled each rising edge |
| hit_now | output | 1 | Early (input-dependent) match flag |
| hit_reg | output | 1 | Late match flag, decoded from state only |

## Verification
The early flag is due in the same cycle as its closing bit. The bench therefore drives `din` and `sync_clr` at the falling edge and compares `hit_now` 1 ns later, before the rising edge that samples the bit. The late flag is due one rising edge later, so the bench compares it in the following cycle against its own expected early value from the previous cycle. The clear takes effect at the edge it is sampled on, so the bench's reference history is emptied at that same edge and never earlier.

// File: rtl/bitseq_pkg.sv
package bitseq_pkg;
    typedef enum logic [1:0] {
        MLY_IDLE   = 2'd0,
        MLY_GOT1   = 2'd1,
        MLY_GOT10  = 2'd2,
        MLY_GOT101 = 2'd3
    } mly_state_t;

    typedef enum logic [2:0] {
        MOR_IDLE   = 3'd0,
        MOR_GOT1   = 3'd1,
        MOR_GOT10  = 3'd2,
        MOR_GOT101 = 3'd3,
        MOR_FOUND  = 3'd4
    } mor_state_t;
endpackage

// File: rtl/bitseq_mealy_fsm.sv
module bitseq_mealy_fsm
    import bitseq_pkg::*;
(
    input  logic clk,
    input  logic sync_clr,
    input  logic din,
    output logic hit
);
    mly_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (sync_clr) state_q <= MLY_IDLE;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MLY_IDLE:   state_d = din ? MLY_GOT1   : MLY_IDLE;
            MLY_GOT1:   state_d = din ? MLY_GOT1   : MLY_GOT10;
            MLY_GOT10:  state_d = din ? MLY_GOT101 : MLY_IDLE;
            MLY_GOT101: state_d = din ? MLY_GOT1   : MLY_GOT10;
        endcase
    end

    // output process: input-dependent, gated by the clear
    always_comb begin
        hit = 1'b0;
        unique case (state_q)
            MLY_GOT101: hit = din & ~sync_clr;
            default:    hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bitseq_moore_fsm.sv
module bitseq_moore_fsm
    import bitseq_pkg::*;
(
    input  logic clk,
    input  logic sync_clr,
    input  logic din,
    output logic hit
);
    mor_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (sync_clr) state_q <= MOR_IDLE;
        else          state_q <= state_d;
    end

    always_comb begin
        state_d = MOR_IDLE;
        unique case (state_q)
            MOR_IDLE:   state_d = din ? MOR_GOT1  : MOR_IDLE;
            MOR_GOT1:   state_d = din ? MOR_GOT1  : MOR_GOT10;
            MOR_GOT10:  state_d = din ? MOR_GOT101 : MOR_IDLE;
            MOR_GOT101: state_d = din ? MOR_FOUND : MOR_GOT10;
            MOR_FOUND:  state_d = din ? MOR_GOT1  : MOR_GOT10;
            default:    state_d = MOR_IDLE;
        endcase
    end

    // output process: present state only
    always_comb begin
        unique case (state_q)
            MOR_FOUND: hit = 1'b1;
            default:   hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/bitseq_watch.sv
module bitseq_watch (
    input  logic clk,
    input  logic sync_clr,
    input  logic din,
    output logic hit_now,
    output logic hit_reg
);
    bitseq_mealy_fsm u_early (
        .clk      (clk),
        .sync_clr (sync_clr),
        .din      (din),
        .hit      (hit_now)
    );

    bitseq_moore_fsm u_late (
        .clk      (clk),
        .sync_clr (sync_clr),
        .din      (din),
        .hit      (hit_reg)
    );
endmodule

// File: rtl/bitseq_watch_chk.sv
module bitseq_watch_chk (
    input logic clk,
    input logic sync_clr,
    input logic din,
    input logic hit_now,
    input logic hit_reg
);
    logic armed = 1'b0;
    always_ff @(posedge clk) begin
        if (sync_clr) armed <= 1'b1;
    end

    AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (!armed)
        $past(sync_clr) |-> !hit_reg);                                  // R1
    AST_EARLY_NEEDS_ONE: assert property (@(posedge clk) disable iff (!armed || sync_clr)
        hit_now |-> din);                                               // R2
    AST_EARLY_NO_REPEAT: assert property (@(posedge clk) disable iff (!armed || sync_clr)
        hit_now |=> !hit_now);                                          // R3
    AST_LATE_TRACKS_EARLY: assert property (@(posedge clk) disable iff (!armed || sync_clr)
        hit_reg == $past(hit_now));                                     // R4
    AST_FOUND_EXITS: assert property (@(posedge clk) disable iff (!armed || sync_clr)
        hit_reg |=> !hit_reg);                                          // R5
    AST_CLEAR_MUTES: assert property (@(posedge clk) disable iff (!armed)
        sync_clr |-> !hit_now);                                         // R6
endmodule

bind bitseq_watch bitseq_watch_chk u_chk (
    .clk      (clk),
    .sync_clr (sync_clr),
    .din      (din),
    .hit_now  (hit_now),
    .hit_reg  (hit_reg)
);

// File: tb/sim_bitseq_watch.sv
module sim_bitseq_watch;
    logic clk = 1'b0;
    logic sync_clr = 1'b1;
    logic din = 1'b0;
    logic hit_now, hit_reg;

    bitseq_watch u0 (
        .clk(clk), .sync_clr(sync_clr), .din(din),
        .hit_now(hit_now), .hit_reg(hit_reg)
    );

    always #2 clk = ~clk;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // reference model
    logic [2:0] hist = 3'b000;
    int unsigned seen = 0;
    bit valid = 1'b0;
    bit prev_exp = 1'b0;
    bit prev_clr = 1'b0;
    bit prev_hreg = 1'b0;
    int early_hits = 0;

    task automatic check(input bit got, input bit exp, input string req);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic step(input bit d, input bit c);
        bit exp_m;
        @(negedge clk);
        din = d;
        sync_clr = c;
        #1;
        exp_m = !c && (seen >= 3) && (hist == 3'b101) && d;
        if (valid) begin
            check(hit_now, exp_m, c ? "R6" : "R2");
            check(hit_reg, prev_exp, prev_clr ? "R1" : "R4");
            if (prev_hreg && hit_reg) check(1'b1, 1'b0, "R5");
        end
        if (hit_now) early_hits++;
        prev_hreg = hit_reg;
        @(posedge clk);
        prev_exp = exp_m;
        prev_clr = c;
        if (c) begin
            hist = 3'b000;
            seen = 0;
            valid = 1'b1;
        end else begin
            hist = {hist[1:0], d};
            if (seen < 3) seen++;
        end
    endtask

    task automatic feed(input logic [15:0] bits, input int n);
        for (int i = n - 1; i >= 0; i--) step(bits[i], 1'b0);
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        step(1'b0, 1'b1);
        step(1'b0, 1'b0);
        check(hit_reg, 1'b0, "R1");
        check(hit_now, 1'b0, "R1");

        // R3: overlapping stream 1011011 gives two early pulses
        step(1'b0, 1'b1);
        early_hits = 0;
        feed(16'b1011011, 7);
        check(early_hits == 2, 1'b1, "R3");

        // R7: prefix kept after mismatch
        step(1'b0, 1'b1);
        early_hits = 0;
        feed(16'b11011, 5);
        check(early_hits == 1, 1'b1, "R7");
        step(1'b0, 1'b1);
        early_hits = 0;
        feed(16'b101011, 6);
        check(early_hits == 1, 1'b1, "R7");

        // R1: bits before clear do not count
        step(1'b0, 1'b1);
        early_hits = 0;
        feed(16'b101, 3);
        step(1'b1, 1'b1);   // R6: clear while in GOT101 with din=1
        step(1'b1, 1'b0);
        check(early_hits == 0, 1'b1, "R1");

        // exhaustive sweep of all 8-bit patterns, each after a clear
        for (int p = 0; p < 256; p++) begin
            step(1'b0, 1'b1);
            feed(16'(p), 8);
        end

        // long random stream with occasional clears
        for (int k = 0; k < 20000; k++) begin
            step(1'($urandom_range(0, 1)), ($urandom_range(0, 99) == 0));
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule